// File: doc/BRIEF.md
# SATA Host Interrupt Aggregation Unit

This block holds the interrupt bookkeeping of a multi-port SATA host controller. Each port owns a 32-bit event register and a matching enable register. Hardware raises per-port events on dedicated input lines. Software clears event bits by writing ones to them. A host-level summary register keeps one sticky bit per port. A port's bit is set while that port has an enabled event pending. A single level interrupt line is driven when the host-level enable is on and any summary bit is set.

Software reaches all of the state through a plain register bus. A write is a one-cycle strobe with an address and data. Read data is a combinational function of the address and of the current register contents. The bus is a control path and has no handshake: every access completes in the cycle it is presented. The block also drives one fatal-pending flag per port. Surrounding logic uses these flags to stop or reset a port without waiting for software.

Top module: `sata_irq_agg`

## Requirements
- R1: Offset 0x000 reads the port count minus one in bits 4:0, with all other bits zero. Offset 0x00C reads the implemented-ports bitmap parameter, limited to the configured port count. Both are read-only.
- R2: A high bit on a port's event input sets the same status bit on the next clock edge, if that bit is a defined event. The defined bits are 0 to 7, 22, 23, 24 and 26 to 31. Undefined bits never set and always read zero.
- R3: Port n's status register sits at 0x100 + 0x80*n + 0x10. A write to it clears every status bit written as one and leaves the bits written as zero untouched.
- R4: When an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Port n's enable register at 0x100 + 0x80*n + 0x14 is written directly and read back. Undefined event bits read zero.
- R6: Summary bit n at 0x008 becomes one on the edge after port n has an event that is both set and enabled. It then stays one, even if the port status is cleared, until a write to 0x008 with bit n set. A pending enabled event at the time of that write keeps the bit set.
- R7: Summary bits of ports that are absent from the implemented-ports bitmap always read zero.
- R8: Bit 1 at 0x004 is the host interrupt enable; all other bits of that register read zero. The interrupt output is high exactly when that enable is one and some summary bit is one.
- R9: The fatal flag of port n is high exactly when any of status bits 27, 28, 29 or 30 is set, whatever the enable register holds.
- R10: Reads of any address that is not mapped return zero. Writes to such addresses change no state. This covers the port windows beyond the configured port count and the unused offsets inside a port window.
- R11: After reset all status, enable, summary and control state is zero, and the interrupt and fatal outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| port_evt | input | NUM_PORTS*32 | Event lines, 32 per port, port n in bits 32n+31:32n |
| host_irq | output | 1 | Level interrupt to the host |
| port_fatal | output | NUM_PORTS | Per-port fatal event pending |

## Verification
The bench compares the read data, the interrupt line and the fatal flags with a behavioural model on every clock. It uses four input patterns. All-ones event bursts separate the defined event bits from the undefined ones. Partial clear masks check that a clear touches only the bits written as one. Event and clear land on the same bit in one cycle, which exposes any clear-wins ordering. An enabled event on an absent port must leave the summary at zero while its status still records the event. A long stretch of random events, writes and addresses then mixes these cases. It includes summary clears that race new pending events.

// File: rtl/sata_irq_pkg.sv
package sata_irq_pkg;
  // Event bits that exist in a port's status/enable registers.
  localparam logic [31:0] EVT_DEFINED = 32'hFDC0_00FF;
  // Events that mark a port as needing recovery.
  localparam logic [31:0] EVT_FATAL   = 32'h7800_0000;

  // Host-level register offsets.
  localparam int unsigned OFF_CAP   = 32'h000;
  localparam int unsigned OFF_GCTL  = 32'h004;
  localparam int unsigned OFF_GSUM  = 32'h008;
  localparam int unsigned OFF_IMPL  = 32'h00C;
  localparam int unsigned GCTL_IE   = 1;

  // Per-port window layout.
  localparam int unsigned PORT_BASE   = 32'h100;
  localparam int unsigned PORT_SHIFT  = 7;      // 0x80 byte window per port
  localparam int unsigned POFF_STAT   = 32'h10;
  localparam int unsigned POFF_MASK   = 32'h14;
endpackage

// File: rtl/sata_port_evt.sv
module sata_port_evt
  import sata_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        clr_wr_i,
  input  logic        mask_wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] st_o,
  output logic [31:0] mk_o,
  output logic        pend_o,
  output logic        fatal_o
);
  logic [31:0] st_q, mk_q;
  logic [31:0] clr_bits, set_bits;

  assign clr_bits = clr_wr_i ? wdata_i : 32'h0;
  assign set_bits = evt_i & EVT_DEFINED;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      mk_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_bits) | set_bits;
      if (mask_wr_i) mk_q <= wdata_i & EVT_DEFINED;
    end
  end

  assign st_o    = st_q;
  assign mk_o    = mk_q;
  assign pend_o  = |(st_q & mk_q);
  assign fatal_o = |(st_q & EVT_FATAL);

  // R4: a hardware set survives a simultaneous software clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & EVT_DEFINED) != 32'h0) |=>
      ((st_q & $past(evt_i & EVT_DEFINED)) == $past(evt_i & EVT_DEFINED)))
    else $error("p_set_wins_r4");

  // R3: bits written as one with no event are gone next cycle
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((st_q & $past(wdata_i & ~evt_i)) == 32'h0))
    else $error("p_clear_r3");

  // R9: a fatal event raises the fatal flag on the following cycle
  p_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & EVT_FATAL) != 32'h0) |=> fatal_o)
    else $error("p_fatal_r9");
endmodule

// File: rtl/sata_irq_summary.sv
module sata_irq_summary #(
  parameter int unsigned          NUM_PORTS = 4,
  parameter logic [NUM_PORTS-1:0] IMPL_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] pend_i,
  input  logic                 clr_wr_i,
  input  logic [NUM_PORTS-1:0] clr_data_i,
  input  logic                 ctl_wr_i,
  input  logic                 ctl_ie_i,
  output logic [NUM_PORTS-1:0] gsum_o,
  output logic                 ie_o,
  output logic                 irq_o
);
  logic [NUM_PORTS-1:0] gsum_q, clr_bits, set_bits;
  logic                 ie_q;

  assign clr_bits = clr_wr_i ? clr_data_i : '0;
  assign set_bits = pend_i & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gsum_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      gsum_q <= (gsum_q & ~clr_bits) | set_bits;
      if (ctl_wr_i) ie_q <= ctl_ie_i;
    end
  end

  assign gsum_o = gsum_q;
  assign ie_o   = ie_q;
  assign irq_o  = ie_q & (|gsum_q);

  // R6: an implemented pending port shows in the summary next cycle
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & IMPL_MASK) != '0) |=>
      ((gsum_q & $past(pend_i & IMPL_MASK)) == $past(pend_i & IMPL_MASK)))
    else $error("p_set_r6");

  // R6: summary bits hold until written with one
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gsum_q & $past(gsum_q & ~clr_bits)) == $past(gsum_q & ~clr_bits)))
    else $error("p_sticky_r6");

  // R8: no interrupt while the host enable is off
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_o |-> !irq_o)
    else $error("p_quiet_r8");
endmodule

// File: rtl/sata_irq_regdec.sv
module sata_irq_regdec
  import sata_irq_pkg::*;
#(
  parameter int unsigned          NUM_PORTS = 4,
  parameter int unsigned          ADDR_W    = 13,
  parameter logic [NUM_PORTS-1:0] IMPL_MASK = '1
) (
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  input  logic [NUM_PORTS*32-1:0] st_all_i,
  input  logic [NUM_PORTS*32-1:0] mk_all_i,
  input  logic [NUM_PORTS-1:0]   gsum_i,
  input  logic                   ie_i,
  output logic [NUM_PORTS-1:0]   st_clr_o,
  output logic [NUM_PORTS-1:0]   mk_wr_o,
  output logic                   gctl_wr_o,
  output logic                   gsum_wr_o,
  output logic [31:0]            rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - PORT_SHIFT;

  logic              in_ports;
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic [PORT_SHIFT-1:0] off;
  logic [NUM_PORTS-1:0]  hit;
  logic              off_stat, off_mask;

  assign in_ports = addr_i >= ADDR_W'(PORT_BASE);
  assign rel      = addr_i - ADDR_W'(PORT_BASE);
  assign idx      = rel[ADDR_W-1:PORT_SHIFT];
  assign off      = rel[PORT_SHIFT-1:0];
  assign off_stat = off == PORT_SHIFT'(POFF_STAT);
  assign off_mask = off == PORT_SHIFT'(POFF_MASK);

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_hit
      assign hit[p]      = in_ports && (idx == IDX_W'(p));
      assign st_clr_o[p] = wr_i && hit[p] && off_stat;
      assign mk_wr_o[p]  = wr_i && hit[p] && off_mask;
    end
  endgenerate

  assign gctl_wr_o = wr_i && (addr_i == ADDR_W'(OFF_GCTL));
  assign gsum_wr_o = wr_i && (addr_i == ADDR_W'(OFF_GSUM));

  always_comb begin
    rdata_o = 32'h0;
    if (addr_i == ADDR_W'(OFF_CAP))       rdata_o = 32'(NUM_PORTS - 1);
    else if (addr_i == ADDR_W'(OFF_GCTL)) rdata_o = 32'(ie_i) << GCTL_IE;
    else if (addr_i == ADDR_W'(OFF_GSUM)) rdata_o = 32'(gsum_i);
    else if (addr_i == ADDR_W'(OFF_IMPL)) rdata_o = 32'(IMPL_MASK);
    else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (hit[i] && off_stat) rdata_o = st_all_i[i*32 +: 32];
        if (hit[i] && off_mask) rdata_o = mk_all_i[i*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/sata_irq_agg.sv
module sata_irq_agg
  import sata_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned ADDR_W     = 13,
  parameter logic [31:0] PORTS_IMPL = 32'h0000_000B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_PORTS*32-1:0] port_evt,
  output logic                    host_irq,
  output logic [NUM_PORTS-1:0]    port_fatal
);
  localparam logic [NUM_PORTS-1:0] IMPL_MASK = PORTS_IMPL[NUM_PORTS-1:0];

  logic [NUM_PORTS*32-1:0] st_all, mk_all;
  logic [NUM_PORTS-1:0]    st_clr, mk_wr, pend, gsum;
  logic                    gctl_wr, gsum_wr, ie;

  sata_irq_regdec #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
  ) u_dec (
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .st_all_i(st_all), .mk_all_i(mk_all), .gsum_i(gsum), .ie_i(ie),
    .st_clr_o(st_clr), .mk_wr_o(mk_wr), .gctl_wr_o(gctl_wr),
    .gsum_wr_o(gsum_wr), .rdata_o(reg_rdata)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      sata_port_evt u_port (
        .clk(clk), .rst_n(rst_n),
        .evt_i(port_evt[p*32 +: 32]),
        .clr_wr_i(st_clr[p]), .mask_wr_i(mk_wr[p]), .wdata_i(reg_wdata),
        .st_o(st_all[p*32 +: 32]), .mk_o(mk_all[p*32 +: 32]),
        .pend_o(pend[p]), .fatal_o(port_fatal[p])
      );
    end
  endgenerate

  sata_irq_summary #(
    .NUM_PORTS(NUM_PORTS), .IMPL_MASK(IMPL_MASK)
  ) u_sum (
    .clk(clk), .rst_n(rst_n), .pend_i(pend),
    .clr_wr_i(gsum_wr), .clr_data_i(reg_wdata[NUM_PORTS-1:0]),
    .ctl_wr_i(gctl_wr), .ctl_ie_i(reg_wdata[GCTL_IE]),
    .gsum_o(gsum), .ie_o(ie), .irq_o(host_irq)
  );

  // R10: at most one port register is written per access
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_clr, mk_wr, gctl_wr, gsum_wr}))
    else $error("p_one_target_r10");
endmodule

// File: tb/sata_irq_agg_tb_top.sv
module sata_irq_agg_tb_top;
  localparam int NP = 4;
  localparam int AW = 13;
  localparam logic [31:0] IMPL = 32'h0000_000B;
  localparam logic [31:0] DEF_BITS = 32'hFDC0_00FF;
  localparam logic [31:0] FAT_BITS = 32'h7800_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP*32-1:0] port_evt = '0;
  logic host_irq;
  logic [NP-1:0] port_fatal;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_st [NP];
  logic [31:0] m_mk [NP];
  logic [NP-1:0] m_gs;
  logic m_en;

  always #2 clk = ~clk;

  sata_irq_agg #(.NUM_PORTS(NP), .ADDR_W(AW), .PORTS_IMPL(IMPL)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_evt(port_evt),
    .host_irq(host_irq), .port_fatal(port_fatal)
  );

  function automatic logic [AW-1:0] paddr(int p, int off);
    return AW'(256 + 128 * p + off);
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    logic [31:0] v = 32'h0;
    if (a == 0) v = NP - 1;
    else if (a == 4) v = {30'h0, m_en, 1'b0};
    else if (a == 8) v = 32'(m_gs);
    else if (a == 12) v = IMPL & ((32'h1 << NP) - 1);
    for (int p = 0; p < NP; p++) begin
      if (a == paddr(p, 16)) v = m_st[p];
      if (a == paddr(p, 20)) v = m_mk[p];
    end
    return v;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [NP-1:0] ng;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_st[p] = '0; m_mk[p] = '0; end
      m_gs = '0; m_en = 1'b0;
      return;
    end
    ng = m_gs;
    if (reg_wr && reg_addr == 8) ng = ng & ~reg_wdata[NP-1:0];
    for (int p = 0; p < NP; p++)
      if (IMPL[p] && ((m_st[p] & m_mk[p]) != 0)) ng[p] = 1'b1;
    for (int p = 0; p < NP; p++) begin
      logic [31:0] c = (reg_wr && reg_addr == paddr(p, 16)) ? reg_wdata : 32'h0;
      m_st[p] = (m_st[p] & ~c) | (port_evt[p*32 +: 32] & DEF_BITS);
      if (reg_wr && reg_addr == paddr(p, 20)) m_mk[p] = reg_wdata & DEF_BITS;
    end
    if (reg_wr && reg_addr == 4) m_en = reg_wdata[1];
    m_gs = ng;
  endtask

  // One clock: inputs set at the falling edge, model and compare after the rising edge.
  task automatic step(string tag, logic wr, logic [AW-1:0] a, logic [31:0] d,
                      logic [NP*32-1:0] ev);
    logic exp_irq;
    logic [NP-1:0] exp_fat;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; port_evt = ev;
    @(posedge clk);
    model_edge();
    #1;
    exp_irq = m_en & (|m_gs);
    for (int p = 0; p < NP; p++) exp_fat[p] = (m_st[p] & FAT_BITS) != 0;
    check(tag, "irq", 32'(host_irq), 32'(exp_irq));
    check(tag, "fatal", 32'(port_fatal), 32'(exp_fat));
    check(tag, "rdata", reg_rdata, exp_read(a));
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    step(tag, 1'b0, a, 32'h0, '0);
  endtask

  task automatic wr(string tag, logic [AW-1:0] a, logic [31:0] d);
    step(tag, 1'b1, a, d, '0);
  endtask

  function automatic logic [NP*32-1:0] ev1(int p, logic [31:0] bits);
    logic [NP*32-1:0] v = '0;
    v[p*32 +: 32] = bits;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_st[p] = '0; m_mk[p] = '0; end
    m_gs = '0; m_en = 1'b0;
    repeat (3) rd("R11", 13'h0);
    @(negedge clk); rst_n = 1'b1;
    // R11: state after reset
    rd("R11", 13'h8); rd("R11", paddr(0, 16)); rd("R11", 13'h4);
    // R1: capability and implemented map
    rd("R1", 13'h0); rd("R1", 13'hC);
    wr("R1", 13'h0, 32'hFFFF_FFFF); wr("R1", 13'hC, 32'h0); rd("R1", 13'h0); rd("R1", 13'hC);
    // R5: enable register write and read back
    wr("R5", paddr(0, 20), 32'hFFFF_FFFF); rd("R5", paddr(0, 20));
    // R2: all-ones event burst on port 1
    step("R2", 1'b0, paddr(1, 16), 32'h0, ev1(1, 32'hFFFF_FFFF));
    rd("R2", paddr(1, 16)); rd("R9", 13'h8);
    // R3: partial clear
    wr("R3", paddr(1, 16), 32'h0000_00F0); rd("R3", paddr(1, 16));
    wr("R3", paddr(1, 16), 32'h7800_0000); rd("R9", paddr(1, 16));
    // R4: event and clear on the same bit
    step("R4", 1'b1, paddr(1, 16), 32'h0000_0001, ev1(1, 32'h0000_0001));
    rd("R4", paddr(1, 16));
    // R6: sticky summary on port 0
    step("R6", 1'b0, 13'h8, 32'h0, ev1(0, 32'h0000_0020));
    rd("R6", 13'h8); rd("R6", 13'h8);
    wr("R6", paddr(0, 16), 32'hFFFF_FFFF); rd("R6", 13'h8); rd("R6", 13'h8);
    // R8: host enable and line
    wr("R8", 13'h4, 32'hFFFF_FFFF); rd("R8", 13'h4);
    wr("R6", 13'h8, 32'h1); rd("R8", 13'h8);
    // R6: clear racing a pending event keeps the bit
    step("R6", 1'b0, 13'h8, 32'h0, ev1(0, 32'h0000_0004));
    wr("R6", 13'h8, 32'h1); rd("R6", 13'h8);
    wr("R6", paddr(0, 16), 32'hFFFF_FFFF); wr("R6", 13'h8, 32'hF); rd("R8", 13'h8);
    // R7: absent port 2
    wr("R7", paddr(2, 20), 32'hFFFF_FFFF);
    step("R7", 1'b0, 13'h8, 32'h0, ev1(2, 32'h0000_0001));
    rd("R7", 13'h8); rd("R7", paddr(2, 16));
    // R9: fatal event with enable off on port 3
    step("R9", 1'b0, paddr(3, 16), 32'h0, ev1(3, 32'h1000_0000));
    rd("R9", paddr(3, 16)); wr("R9", paddr(3, 16), 32'h1000_0000); rd("R9", 13'h8);
    // R10: unmapped reads and writes
    wr("R10", 13'h20, 32'hFFFF_FFFF); rd("R10", 13'h20);
    wr("R10", paddr(NP, 16), 32'hFFFF_FFFF); rd("R10", paddr(NP, 16));
    wr("R10", paddr(1, 24), 32'hFFFF_FFFF); rd("R10", paddr(1, 24));
    rd("R10", paddr(1, 17)); rd("R10", 13'h1FFF); rd("R10", paddr(1, 16));
    // R4: random mix of events, clears and reads
    for (int i = 0; i < 600; i++) begin
      int p = $urandom_range(0, NP);
      int k = $urandom_range(0, 5);
      logic [AW-1:0] a;
      logic [NP*32-1:0] ev = '0;
      case (k)
        0: a = 13'h8;
        1: a = 13'h4;
        2: a = paddr(p, 20);
        default: a = paddr(p, 16);
      endcase
      for (int q = 0; q < NP; q++)
        if ($urandom_range(0, 3) == 0) ev[q*32 +: 32] = 32'h1 << $urandom_range(0, 31);
      step("R4", $urandom_range(0, 1) == 1, a, $urandom, ev);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule